// File: doc/BRIEF.md
# Dual-Output PWM Pulse Steering

This block is a fixed-frequency digital pulse-width modulator with two gate outputs. A free-running counter acts as the sawtooth. Each period opens with a dead-time window in which both outputs are held low and a clock marker is high. When the marker falls, a pulse starts on the selected output or outputs. The pulse ends at the earliest of three events: the ramp reaching the duty command, a current-limit flag, or an overcurrent flag. Once ended, it stays low until the next period.

A blanking window at the start of each pulse hides the duty-crossing and current-limit terminations, so that switching noise cannot cut a pulse short. The overcurrent flag is never blanked. It removes the drive in the same cycle and raises a trip output that holds the outputs low until a period ends with the flag clear. A mode pin selects one of two steering schemes. In in-phase mode, both outputs carry the same pulse every period. In alternating mode, each output carries a pulse only on every other period.

The duty command and the flags are sampled every cycle as plain control levels, so there is no handshake on any port.

Top module: `pwm_steer`

## Requirements
- R1: While reset is active, `out_a`, `out_b` and `trip` are low and `clk_mark` is high. The first cycle after reset is the first cycle of a period.
- R2: Every period lasts PERIOD cycles. `clk_mark` is high for exactly the first DEAD of them, and both outputs are low whenever `clk_mark` is high.
- R3: A pulse rises only in the first cycle after `clk_mark` falls. With no flag active, it lasts max(`duty`, BLANK) cycles, capped at PERIOD-DEAD cycles.
- R4: A `duty` of 0 produces no pulse in that period.
- R5: During the first BLANK cycles of a pulse, the duty crossing and `cur_lim` are ignored. A nonzero duty therefore always gives at least BLANK cycles.
- R6: After blanking, `cur_lim` high drops the pulse in the same cycle.
- R7: `over_cur` high drops both outputs in the same cycle, even inside blanking. `trip` is high from the next cycle on and holds the outputs low. `trip` clears at the end of the first period in whose last cycle `over_cur` is low.
- R8: A terminated pulse stays low for the rest of its period, even if the terminating flag goes away.
- R9: With `mode` = 0, `out_a` and `out_b` are identical. With `mode` = 1, the pulses alternate between `out_a` and `out_b` from one period to the next, and the two outputs are never high together.
- R10: While `enable` is low or `fault_in` is high, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty | input | CNT_W | Duty command, in cycles of pulse length |
| cur_lim | input | 1 | Current-limit flag (blanked) |
| over_cur | input | 1 | Overcurrent flag (never blanked) |
| enable | input | 1 | Supply-good / run enable |
| fault_in | input | 1 | External fault, forces outputs low |
| mode | input | 1 | 0 = in-phase, 1 = alternating |
| out_a | output | 1 | Gate output A |
| out_b | output | 1 | Gate output B |
| clk_mark | output | 1 | High during the dead-time window |
| trip | output | 1 | Overcurrent trip indication |

## Verification
A wrong period counter shows up within one period as a `clk_mark` run other than DEAD cycles, or as pulse lengths off by the miscount. A PWM latch that fails to clear or to set shows up in the same period as a width that ignores a one-cycle current-limit flag or a zero duty. A steering toggle that is stuck puts two consecutive alternating-mode pulses on the same output, which is visible after two periods. A trip state that does not hold or release shows up as a pulse right after an overcurrent event, or as a missing pulse one period later.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  typedef enum logic {
    STEER_INPHASE   = 1'b0,
    STEER_ALTERNATE = 1'b1
  } steer_mode_e;
endpackage

// File: rtl/pwm_ramp.sv
// Period counter: sawtooth position, dead-time window and period markers.
module pwm_ramp #(
  parameter int PERIOD = 32,
  parameter int DEAD   = 4,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             dead_o,
  output logic             start_next_o,
  output logic             wrap_o,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] DEAD_C = CNT_W'(DEAD);
  localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(DEAD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign dead_o       = (cnt_q < DEAD_C);
  assign start_next_o = (cnt_q == PRE_C);
  assign wrap_o       = (cnt_q == LAST_C);
  assign pos_o        = dead_o ? '0 : (cnt_q - DEAD_C);
endmodule

// File: rtl/pwm_term.sv
// Set/reset pulse latch with blanking and the sticky overcurrent trip.
module pwm_term #(
  parameter int BLANK = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dead,
  input  logic             start_next,
  input  logic             wrap,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] duty,
  input  logic             cur_lim,
  input  logic             over_cur,
  output logic             pulse_o,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);

  logic live_q, trip_q;
  logic blanked, crossed, cut;

  assign blanked = (pos < BLANK_C);
  assign crossed = (pos >= duty);
  assign cut     = over_cur | (!blanked & (crossed | cur_lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              live_q <= 1'b0;
    else if (start_next)     live_q <= (duty != '0);
    else if (!dead && cut)   live_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trip_q <= 1'b0;
    else if (over_cur) trip_q <= 1'b1;
    else if (wrap)     trip_q <= 1'b0;
  end

  assign pulse_o = live_q & !dead & !cut;
  assign trip_o  = trip_q;
endmodule

// File: rtl/pwm_route.sv
// Period toggle and steering of the gated pulse onto the two legs.
module pwm_route
  import pwm_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  logic       mode,
  input  logic       pulse,
  output logic [1:0] legs
);
  steer_mode_e mode_e;
  logic        phase_q;

  assign mode_e = steer_mode_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= 1'b0;
    else if (wrap) phase_q <= !phase_q;
  end

  for (genvar i = 0; i < 2; i++) begin : g_leg
    logic sel;
    assign sel     = (mode_e == STEER_ALTERNATE) ? (phase_q == 1'(i)) : 1'b1;
    assign legs[i] = pulse & sel;
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
  parameter int PERIOD = 32,
  parameter int DEAD   = 4,
  parameter int BLANK  = 3,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty,
  input  logic             cur_lim,
  input  logic             over_cur,
  input  logic             enable,
  input  logic             fault_in,
  input  logic             mode,
  output logic             out_a,
  output logic             out_b,
  output logic             clk_mark,
  output logic             trip
);
  logic             dead, start_next, wrap, pulse, allow;
  logic [CNT_W-1:0] pos;
  logic [1:0]       legs;

  pwm_ramp #(.PERIOD(PERIOD), .DEAD(DEAD), .CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .dead_o(dead), .start_next_o(start_next),
    .wrap_o(wrap), .pos_o(pos)
  );

  pwm_term #(.BLANK(BLANK), .CNT_W(CNT_W)) u_term (
    .clk(clk), .rst_n(rst_n), .dead(dead), .start_next(start_next),
    .wrap(wrap), .pos(pos), .duty(duty), .cur_lim(cur_lim),
    .over_cur(over_cur), .pulse_o(pulse), .trip_o(trip)
  );

  assign allow = enable & !fault_in & !trip;

  pwm_route u_route (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .mode(mode),
    .pulse(pulse & allow), .legs(legs)
  );

  assign out_a    = legs[0];
  assign out_b    = legs[1];
  assign clk_mark = dead;
endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk (
  input logic clk,
  input logic rst_n,
  input logic over_cur,
  input logic enable,
  input logic fault_in,
  input logic mode,
  input logic out_a,
  input logic out_b,
  input logic clk_mark,
  input logic trip
);
  p_dead_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_mark |-> (!out_a && !out_b));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_a) && $past(enable) && !$past(fault_in)) |-> $past(clk_mark));

  p_oc_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    over_cur |-> (!out_a && !out_b));

  p_oc_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    over_cur |=> trip);

  p_alt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> !(out_a && out_b));

  p_inphase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (out_a == out_b));

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || fault_in) |-> (!out_a && !out_b));
endmodule

bind pwm_steer pwm_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .over_cur(over_cur), .enable(enable),
  .fault_in(fault_in), .mode(mode), .out_a(out_a), .out_b(out_b),
  .clk_mark(clk_mark), .trip(trip)
);

// File: tb/pwm_steer_bench.sv
`timescale 1ns/1ps
module pwm_steer_bench;
  localparam int PERIOD = 32;
  localparam int DEAD   = 4;
  localparam int BLANK  = 3;
  localparam int CNT_W  = 8;
  localparam int NV     = 12;
  // fields: mode, duty, cur_lim from pos (held), over_cur at pos, exp A, exp B (two periods)
  localparam logic [47:0] VEC [0:NV-1] = '{
    {8'd0, 8'd10,  8'hFF, 8'hFF, 8'd20, 8'd20},
    {8'd1, 8'd10,  8'hFF, 8'hFF, 8'd10, 8'd10},
    {8'd0, 8'd0,   8'hFF, 8'hFF, 8'd0,  8'd0 },
    {8'd0, 8'd1,   8'hFF, 8'hFF, 8'd6,  8'd6 },
    {8'd0, 8'd200, 8'hFF, 8'hFF, 8'd56, 8'd56},
    {8'd0, 8'd20,  8'd8,  8'hFF, 8'd16, 8'd16},
    {8'd0, 8'd20,  8'd1,  8'hFF, 8'd6,  8'd6 },
    {8'd0, 8'd20,  8'hFF, 8'd1,  8'd2,  8'd2 },
    {8'd1, 8'd20,  8'hFF, 8'd0,  8'd0,  8'd0 },
    {8'd1, 8'd28,  8'd15, 8'hFF, 8'd15, 8'd15},
    {8'd0, 8'd5,   8'd2,  8'hFF, 8'd6,  8'd6 },
    {8'd0, 8'd27,  8'hFF, 8'hFF, 8'd54, 8'd54}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] duty = '0;
  logic cur_lim = 1'b0, over_cur = 1'b0, enable = 1'b1, fault_in = 1'b0, mode = 1'b0;
  logic out_a, out_b, clk_mark, trip;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pwm_steer #(.PERIOD(PERIOD), .DEAD(DEAD), .BLANK(BLANK), .CNT_W(CNT_W)) u_pwm_steer (
    .clk(clk), .rst_n(rst_n), .duty(duty), .cur_lim(cur_lim), .over_cur(over_cur),
    .enable(enable), .fault_in(fault_in), .mode(mode), .out_a(out_a), .out_b(out_b),
    .clk_mark(clk_mark), .trip(trip)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0, 4, 11: return "R3";
      1:        return "R9";
      2:        return "R4";
      3, 6, 10: return "R5";
      5, 9:     return "R6";
      default:  return "R7";
    endcase
  endfunction

  // wait for the first cycle of a period (clk_mark rising), observed at a negedge
  task automatic sync_period();
    logic prev;
    @(negedge clk);
    prev = clk_mark;
    forever begin
      @(negedge clk);
      if (clk_mark && !prev) break;
      prev = clk_mark;
    end
  endtask

  // runs two periods from a period start; returns high counts per output per period
  task automatic run_two(input logic m, input int d, input int cl_at, input bit cl_hold,
                         input int oc_at, output int a1, output int b1, output int a2,
                         output int b2, output int viol);
    mode = m; duty = CNT_W'(d);
    a1 = 0; b1 = 0; a2 = 0; b2 = 0; viol = 0;
    sync_period();
    for (int c = 0; c < 2 * PERIOD; c++) begin
      int p;
      p = (c % PERIOD) - DEAD;
      cur_lim  = (p >= 0) && (cl_hold ? (p >= cl_at) : (p == cl_at));
      over_cur = (p >= 0) && (p == oc_at);
      #1;
      if (clk_mark && (out_a || out_b)) viol++;
      if (c < PERIOD) begin a1 += int'(out_a); b1 += int'(out_b); end
      else            begin a2 += int'(out_a); b2 += int'(out_b); end
      @(negedge clk);
    end
    cur_lim = 1'b0; over_cur = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a1, b1, a2, b2, viol, marks;
    // R1 reset state
    #11;
    check(!out_a && !out_b, "R1 outputs low in reset", int'(out_a | out_b), 0);
    check(!trip, "R1 trip low in reset", int'(trip), 0);
    check(clk_mark, "R1 clk_mark high in reset", int'(clk_mark), 1);
    @(negedge clk); rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      run_two(v[40], int'(v[39:32]), int'(v[31:24]), 1'b1, int'(v[23:16]),
              a1, b1, a2, b2, viol);
      check(a1 + a2 == int'(v[15:8]), {vec_tag(i), " out_a width"}, a1 + a2, int'(v[15:8]));
      check(b1 + b2 == int'(v[7:0]),  {vec_tag(i), " out_b width"}, b1 + b2, int'(v[7:0]));
      check(viol == 0, "R2 outputs low in dead time", viol, 0);
    end

    // R2 dead-time length
    sync_period();
    marks = 0;
    for (int c = 0; c < PERIOD; c++) begin
      marks += int'(clk_mark);
      @(negedge clk);
    end
    check(marks == DEAD, "R2 clk_mark cycles per period", marks, DEAD);

    // R8 one-cycle current limit still ends the pulse for the period
    run_two(1'b0, 20, 8, 1'b0, 255, a1, b1, a2, b2, viol);
    check(a1 == 8 && a2 == 8, "R8 latch holds after one-cycle cur_lim", a1, 8);

    // R9 alternation: one output per period, swapping
    run_two(1'b1, 10, 255, 1'b0, 255, a1, b1, a2, b2, viol);
    check((a1 == 10 && b1 == 0 && a2 == 0 && b2 == 10) ||
          (a1 == 0 && b1 == 10 && a2 == 10 && b2 == 0),
          "R9 alternate steering", a1 * 100 + a2, 1000);

    // R10 enable low and fault_in high
    enable = 1'b0;
    run_two(1'b0, 10, 255, 1'b0, 255, a1, b1, a2, b2, viol);
    check(a1 + a2 + b1 + b2 == 0, "R10 enable low", a1 + a2 + b1 + b2, 0);
    enable = 1'b1; fault_in = 1'b1;
    run_two(1'b0, 10, 255, 1'b0, 255, a1, b1, a2, b2, viol);
    check(a1 + a2 + b1 + b2 == 0, "R10 fault_in high", a1 + a2 + b1 + b2, 0);
    fault_in = 1'b0;

    // R7 trip sequence
    mode = 1'b0; duty = CNT_W'(20);
    sync_period();
    for (int c = 0; c < DEAD + 5; c++) @(negedge clk);
    check(out_a, "R7 pulse present before over_cur", int'(out_a), 1);
    over_cur = 1'b1; #1;
    check(!out_a && !out_b, "R7 same-cycle cut", int'(out_a | out_b), 0);
    @(negedge clk); over_cur = 1'b0; #1;
    check(trip, "R7 trip raised", int'(trip), 1);
    check(!out_a, "R8 stays low after over_cur", int'(out_a), 0);
    sync_period(); #1;
    check(!trip, "R7 trip cleared at period end", int'(trip), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule